// File: doc/BRIEF.md
# Cut-Through Transmit Packet Gate

This block sits between a bus master that fills an outgoing packet buffer and the link that drains it. Packets arrive as 32-bit words, with a marker on the final word. The block decides when the link may begin reading a packet. In cut-through operation, draining starts once enough words are buffered to reach a programmable level, or once the final word is in, whichever happens first. In store-and-forward operation, draining starts only when the complete packet is held.

If the link drains the buffer dry before the packet's final word has been written, the block ends the outgoing packet with an error beat and raises an underrun pulse. It then rewinds to the first word of the packet and latches a retry mode. The retry waits for the whole packet before sending it again. Store-and-forward is also forced when the configured retry limit is zero. Under store-and-forward, a packet that does not fit in the buffer is dropped and flagged.

Top module: `txq_gate`

## Requirements
- R1: The 2-bit level select `cfg_thr`, loaded when `cfg_we` is high, chooses the start level in words for a 512-word buffer: 00 = 512, 01 = 436, 10 = 256, 11 = 128. After any reset it holds 01.
- R2: With a cut-through select (01, 10, 11), `rd_valid` first rises two cycles after the write that brings the packet's word count to the level, or after the write carrying `wr_last`, whichever comes first.
- R3: With select 00, `rd_valid` stays low for a packet until its `wr_last` word has been written.
- R4: When `retry_limit` is zero, every packet waits for its `wr_last` word, whatever the select holds.
- R5: If the link is ready while a packet is being sent, all written words have been read, and `wr_last` has not yet been written, the block presents one beat with `rd_valid`, `rd_err` and `rd_last` all high, and `underrun` is high for that one cycle.
- R6: After an underrun, `retry_mode` is high, `rd_valid` stays low until the packet's `wr_last` word is written, and the packet is then resent from its first word with no error.
- R7: Once a retried packet has been read out in full without error, `retry_mode` returns low, and the next packet again starts at the programmed level.
- R8: While store-and-forward is in force, a write of word 513 of a packet raises `overflow` for that cycle. The packet is discarded up to and including its `wr_last` word, and nothing of it is sent.
- R9: Any of `por_rst`, `glb_rst` or `bus_rst` restores the level select to 01 and clears `retry_mode`, the buffered packet and the output handshake.
- R10: Words are read out in write order, with `rd_last` on the final word. `wr_ready` is low from the write of `wr_last` until that packet has been fully read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, active high |
| glb_rst | input | 1 | Global reset, active high |
| bus_rst | input | 1 | Bus reset, active high |
| cfg_we | input | 1 | Load strobe for the level select |
| cfg_thr | input | 2 | Start level select |
| retry_limit | input | 4 | Configured retry count; zero forces store-and-forward |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | Write word accepted when high with `wr_valid` |
| wr_data | input | 32 | Write word |
| wr_last | input | 1 | Final word of the packet |
| rd_valid | output | 1 | Read beat valid |
| rd_ready | input | 1 | Link accepts the read beat |
| rd_data | output | 32 | Read word |
| rd_last | output | 1 | Final beat of the outgoing packet |
| rd_err | output | 1 | Beat ends the packet in error (underrun) |
| underrun | output | 1 | One-cycle underrun event |
| overflow | output | 1 | One-cycle oversize-packet event |
| retry_mode | output | 1 | Store-and-forward retry latch |

## Verification
On every cycle, the embedded assertions check the following. A store-and-forward start never happens before the final word is held. A cut-through start never happens below the level. An underrun always produces a complete error beat, and the latch and rewind follow it. An overflow empties the packet count. Writes are stalled while a finished packet is pending. The read count never passes the write count. Only the bench scenarios can show the rest: the exact start word for each select, the reset default of the level, the reordering-free replay of the whole packet after an underrun, and the return to cut-through for the packet after a clean retry.

// File: rtl/txq_pkg.sv
`timescale 1ns/1ps
package txq_pkg;

  // Start level in words for a select code; scaled from a 512-word buffer.
  function automatic int unsigned thr_words(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'b00:   return depth;
      2'b01:   return (depth * 436) / 512;
      2'b10:   return depth / 2;
      default: return depth / 4;
    endcase
  endfunction

endpackage

// File: rtl/txq_cfg.sv
`timescale 1ns/1ps
module txq_cfg
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned CW    = 10
) (
  input  logic          clk,
  input  logic          arst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_thr,
  input  logic [3:0]    retry_limit,
  input  logic          retry_mode,
  output logic          saf,
  output logic [CW-1:0] thr
);

  logic [1:0] thr_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)        thr_q <= 2'b01;
    else if (cfg_we) thr_q <= cfg_thr;
  end

  assign saf = (thr_q == 2'b00) || retry_mode || (retry_limit == 4'd0);
  assign thr = CW'(thr_words(thr_q, DEPTH));

  // R9: the first sampled cycle out of reset sees the default select
  assert_reset_default_R9: assert property (@(posedge clk) disable iff (arst)
    $fell(arst) |-> (thr_q == 2'b01))
    else $error("select not at default after reset");

endmodule

// File: rtl/txq_ram.sv
`timescale 1ns/1ps
module txq_ram #(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/txq_ctrl.sv
`timescale 1ns/1ps
module txq_ctrl #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned AW    = 9,
  parameter int unsigned CW    = 10
) (
  input  logic          clk,
  input  logic          arst,
  input  logic          saf,
  input  logic [CW-1:0] thr,
  input  logic          wr_valid,
  input  logic          wr_last,
  output logic          wr_ready,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic          rd_last,
  output logic          rd_err,
  output logic          mem_we,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          underrun,
  output logic          overflow,
  output logic          retry_mode
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [AW-1:0] base;
  logic [CW-1:0] wcnt, rcnt;
  logic          eop_w, sending, dropping, retry_q;

  // named internal events
  logic wr_fire, accept, ev_overflow, ev_underrun, ev_go, ev_done, empty, rd_fire;

  assign empty       = (rcnt == wcnt);
  assign wr_ready    = !eop_w && (dropping || (wcnt < FULL) || (saf && !sending));
  assign wr_fire     = wr_valid && wr_ready;
  assign ev_overflow = wr_fire && !dropping && saf && !sending && (wcnt == FULL);
  assign accept      = wr_fire && !dropping && !ev_overflow;
  assign ev_underrun = sending && empty && !eop_w && rd_ready;
  assign rd_valid    = sending && (!empty || (!eop_w && rd_ready));
  assign rd_err      = ev_underrun;
  assign rd_last     = ev_underrun || (sending && !empty && eop_w && ((rcnt + CW'(1)) == wcnt));
  assign rd_fire     = rd_valid && rd_ready;
  assign ev_done     = rd_fire && !ev_underrun && rd_last;
  assign ev_go       = !sending && !dropping && (wcnt != '0) && (eop_w || (!saf && (wcnt >= thr)));

  assign mem_we     = accept;
  assign waddr      = base + wcnt[AW-1:0];
  assign raddr      = base + rcnt[AW-1:0];
  assign underrun   = ev_underrun;
  assign overflow   = ev_overflow;
  assign retry_mode = retry_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      base     <= '0;
      wcnt     <= '0;
      rcnt     <= '0;
      eop_w    <= 1'b0;
      sending  <= 1'b0;
      dropping <= 1'b0;
      retry_q  <= 1'b0;
    end else begin
      if (accept) begin
        wcnt <= wcnt + CW'(1);
        if (wr_last) eop_w <= 1'b1;
      end
      if (ev_overflow) begin
        wcnt     <= '0;
        dropping <= !wr_last;
      end
      if (dropping && wr_fire && wr_last) dropping <= 1'b0;
      if (ev_go) sending <= 1'b1;
      if (rd_fire && !ev_underrun) rcnt <= rcnt + CW'(1);
      if (ev_underrun) begin
        rcnt    <= '0;
        sending <= 1'b0;
        retry_q <= 1'b1;
      end
      if (ev_done) begin
        base    <= base + wcnt[AW-1:0];
        wcnt    <= '0;
        rcnt    <= '0;
        eop_w   <= 1'b0;
        sending <= 1'b0;
        retry_q <= 1'b0;
      end
    end
  end

  assert_saf_waits_eop_R3: assert property (@(posedge clk) disable iff (arst)
    ($rose(sending) && $past(saf)) |-> $past(eop_w))
    else $error("store-and-forward start without final word");

  assert_ct_level_R2: assert property (@(posedge clk) disable iff (arst)
    ($rose(sending) && !$past(eop_w)) |-> ($past(wcnt) >= $past(thr)))
    else $error("cut-through start below level");

  assert_underrun_beat_R5: assert property (@(posedge clk) disable iff (arst)
    ev_underrun |-> (rd_valid && rd_last && rd_err))
    else $error("underrun without error beat");

  assert_retry_latch_R6: assert property (@(posedge clk) disable iff (arst)
    ev_underrun |=> (retry_q && !sending && (rcnt == '0)))
    else $error("no rewind or latch after underrun");

  assert_retry_clear_R7: assert property (@(posedge clk) disable iff (arst)
    (ev_done && retry_q) |=> !retry_q)
    else $error("retry latch kept after clean send");

  assert_overflow_drop_R8: assert property (@(posedge clk) disable iff (arst)
    ev_overflow |=> ((wcnt == '0) && !sending))
    else $error("oversize packet not discarded");

  assert_hold_after_eop_R10: assert property (@(posedge clk) disable iff (arst)
    eop_w |-> !wr_ready)
    else $error("write accepted while packet pending");

  assert_read_behind_R10: assert property (@(posedge clk) disable iff (arst)
    rcnt <= wcnt)
    else $error("read count passed write count");

endmodule

// File: rtl/txq_gate.sv
`timescale 1ns/1ps
module txq_gate #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned W     = 32
) (
  input  logic         clk,
  input  logic         por_rst,
  input  logic         glb_rst,
  input  logic         bus_rst,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_thr,
  input  logic [3:0]   retry_limit,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [W-1:0] wr_data,
  input  logic         wr_last,
  output logic         rd_valid,
  input  logic         rd_ready,
  output logic [W-1:0] rd_data,
  output logic         rd_last,
  output logic         rd_err,
  output logic         underrun,
  output logic         overflow,
  output logic         retry_mode
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          arst, saf, mem_we;
  logic [CW-1:0] thr;
  logic [AW-1:0] waddr, raddr;

  assign arst = por_rst | glb_rst | bus_rst;

  txq_cfg #(.DEPTH(DEPTH), .CW(CW)) cfg_i (
    .clk(clk), .arst(arst), .cfg_we(cfg_we), .cfg_thr(cfg_thr),
    .retry_limit(retry_limit), .retry_mode(retry_mode), .saf(saf), .thr(thr)
  );

  txq_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) ctrl_i (
    .clk(clk), .arst(arst), .saf(saf), .thr(thr),
    .wr_valid(wr_valid), .wr_last(wr_last), .wr_ready(wr_ready),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_last(rd_last), .rd_err(rd_err),
    .mem_we(mem_we), .waddr(waddr), .raddr(raddr),
    .underrun(underrun), .overflow(overflow), .retry_mode(retry_mode)
  );

  txq_ram #(.W(W), .AW(AW)) ram_i (
    .clk(clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(rd_data)
  );

endmodule

// File: tb/txq_gate_tb_top.sv
`timescale 1ns/1ps
module txq_gate_tb_top;

  logic        clk = 1'b0;
  logic        por_rst = 1'b1, glb_rst = 1'b0, bus_rst = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_thr = 2'b00;
  logic [3:0]  retry_limit = 4'd3;
  logic        wr_valid = 1'b0, wr_last = 1'b0, rd_ready = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready, rd_valid, rd_last, rd_err, underrun, overflow, retry_mode;
  logic [31:0] rd_data;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit vis, ovf_seen;

  always #10 clk = ~clk;

  txq_gate dut_i (
    .clk(clk), .por_rst(por_rst), .glb_rst(glb_rst), .bus_rst(bus_rst),
    .cfg_we(cfg_we), .cfg_thr(cfg_thr), .retry_limit(retry_limit),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
    .rd_err(rd_err), .underrun(underrun), .overflow(overflow), .retry_mode(retry_mode)
  );

  // sel, retry limit, length, expected words written at first rd_valid
  localparam logic [25:0] VEC [0:6] = '{
    {2'b01, 4'd3, 10'd500, 10'd436},
    {2'b10, 4'd3, 10'd300, 10'd256},
    {2'b11, 4'd3, 10'd200, 10'd128},
    {2'b11, 4'd3, 10'd50,  10'd50 },
    {2'b00, 4'd3, 10'd300, 10'd300},
    {2'b11, 4'd0, 10'd200, 10'd200},
    {2'b10, 4'd1, 10'd256, 10'd256}
  };

  function automatic logic [31:0] pat(input int pid, input int i);
    return {8'(pid), 24'(i)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_reset(input int which);
    @(negedge clk);
    if (which == 0) por_rst = 1'b1; else if (which == 1) glb_rst = 1'b1; else bus_rst = 1'b1;
    repeat (3) @(negedge clk);
    por_rst = 1'b0; glb_rst = 1'b0; bus_rst = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] sel);
    @(negedge clk);
    cfg_we = 1'b1; cfg_thr = sel;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one word; afterwards vis holds rd_valid two edges after acceptance
  task automatic put_word(input logic [31:0] d, input bit last);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_last = last;
    #1;
    ovf_seen = overflow;
    if (!wr_ready) chk(1'b0, "R10", "wr_ready low during write", 0, 1);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
    @(posedge clk);
    @(negedge clk);
    #1;
    vis = rd_valid;
  endtask

  task automatic drain(input int pid, output int good, output int last_at, output int data_bad, output bit errb);
    good = 0; last_at = -1; data_bad = 0; errb = 1'b0;
    for (int g = 0; g < 1200; g++) begin
      @(negedge clk);
      rd_ready = 1'b1;
      #1;
      if (rd_valid) begin
        if (rd_err) begin
          errb = 1'b1;
          chk(rd_last && underrun, "R5", "error beat last/underrun", int'({rd_last, underrun}), 3);
          break;
        end
        if (rd_data !== pat(pid, good)) data_bad++;
        good++;
        if (rd_last) begin
          last_at = good;
          break;
        end
      end
    end
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic run_pkt(input bit do_cfg, input logic [1:0] sel, input logic [3:0] lim,
                         input int len, input int pid, input int exp_start, input string req);
    int start;
    int good, last_at, dbad;
    bit errb;
    if (do_cfg) set_cfg(sel);
    retry_limit = lim;
    start = -1;
    for (int i = 0; i < len; i++) begin
      put_word(pat(pid, i), i == len - 1);
      if (vis && start < 0) start = i + 1;
    end
    chk(start == exp_start, req, "words written at start", start, exp_start);
    drain(pid, good, last_at, dbad, errb);
    chk(!errb && dbad == 0 && good == len && last_at == len, "R10", "packet delivery", good - dbad, len);
  endtask

  initial begin
    int good, last_at, dbad;
    bit errb;
    bit early;
    repeat (3) @(negedge clk);
    por_rst = 1'b0;
    #1;
    // reset state
    chk(wr_ready && !rd_valid && !retry_mode && !underrun && !overflow, "R9", "reset outputs",
        int'({wr_ready, rd_valid, retry_mode}), 4);
    // default select 01 without any load
    run_pkt(1'b0, 2'b01, 4'd3, 450, 1, 436, "R1");

    // vector table
    foreach (VEC[k]) begin
      run_pkt(1'b1, VEC[k][25:24], VEC[k][23:20], int'(VEC[k][19:10]), 10 + k,
              int'(VEC[k][9:0]), (VEC[k][25:24] == 2'b00) ? "R3" :
              (VEC[k][23:20] == 4'd0) ? "R4" : "R2");
    end

    // underrun and retry
    set_cfg(2'b11);
    retry_limit = 4'd3;
    for (int i = 0; i < 128; i++) put_word(pat(30, i), 1'b0);
    chk(vis, "R2", "start at 128 words", int'(vis), 1);
    drain(30, good, last_at, dbad, errb);
    chk(errb && good == 128 && dbad == 0, "R5", "beats before underrun", good, 128);
    #1;
    chk(retry_mode, "R6", "retry latch set", int'(retry_mode), 1);
    early = 1'b0;
    for (int i = 128; i < 200; i++) begin
      put_word(pat(30, i), i == 199);
      if (vis && i < 199) early = 1'b1;
    end
    chk(!early && vis, "R6", "retry waits for final word", int'(early), 0);
    drain(30, good, last_at, dbad, errb);
    chk(!errb && dbad == 0 && good == 200 && last_at == 200, "R6", "replay from first word", good - dbad, 200);
    #1;
    chk(!retry_mode && wr_ready, "R7", "latch cleared after clean send", int'(retry_mode), 0);
    run_pkt(1'b0, 2'b11, 4'd3, 200, 31, 128, "R7");

    // oversize packet under store-and-forward
    set_cfg(2'b00);
    begin
      int ovf_at;
      bit any_vis;
      ovf_at = -1; any_vis = 1'b0;
      for (int i = 0; i < 513; i++) begin
        put_word(pat(40, i), i == 512);
        if (ovf_seen && ovf_at < 0) ovf_at = i + 1;
        if (vis) any_vis = 1'b1;
      end
      chk(ovf_at == 513, "R8", "overflow on word 513", ovf_at, 513);
      chk(!any_vis && wr_ready, "R8", "oversize packet not sent", int'(any_vis), 0);
    end
    run_pkt(1'b0, 2'b00, 4'd3, 10, 41, 10, "R8");

    // bus reset restores default select
    set_cfg(2'b11);
    pulse_reset(2);
    run_pkt(1'b0, 2'b11, 4'd3, 450, 50, 436, "R9");

    // global reset clears the retry latch
    set_cfg(2'b11);
    for (int i = 0; i < 128; i++) put_word(pat(60, i), 1'b0);
    drain(60, good, last_at, dbad, errb);
    #1;
    chk(errb && retry_mode, "R6", "underrun before reset", int'(retry_mode), 1);
    pulse_reset(1);
    #1;
    chk(!retry_mode && wr_ready && !rd_valid, "R9", "global reset clears state", int'(retry_mode), 0);
    run_pkt(1'b0, 2'b01, 4'd3, 440, 61, 436, "R9");

    // power-on reset after a select change
    set_cfg(2'b10);
    pulse_reset(0);
    run_pkt(1'b0, 2'b01, 4'd3, 437, 62, 436, "R1");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule